// File: doc/BRIEF.md
# Serial Loopback Pseudo-Random Byte Generator

This block produces a continuous stream of pseudo-random bytes without a parallel shift-register polynomial. A byte-wide full-duplex serial engine sends a transmit byte out on its data-out line, most significant bit first. Two single-bit registers, clocked on the serial clock's rising edge, delay that line by one and two bit times. The exclusive-OR of the two delayed bits is fed back into the engine's data-in line, and the engine assembles the incoming bits into the next byte.

Every finished byte lands in a one-entry receive holder. When the consumer accepts it, the byte is offered on the output with a one-cycle valid pulse. In the same cycle it is copied back into the one-entry transmit holder, which starts the next transfer. A seed can be loaded while generation is disabled. The serial clock comes from a programmable divider of the system clock, and the serial pins are brought out so the loop can be observed.

Top module: `spi_loop_rng`

## Requirements
- R1: After reset, `rnd_valid`, `sck` and `sdo` are 0. The transmit holder contains the default seed 0x2C, both feedback bits are 0 and no transfer runs. The first byte produced after `enable` rises is 0x1D.
- R2: A transfer sends the transmit byte on `sdo` most significant bit first, one bit per serial clock period. `sdo` changes only when `sck` falls or when a transfer begins.
- R3: `sdi` is the XOR of two feedback bits. On each rising edge of `sck`, the first bit takes `sdo` and the second takes the old value of the first. Both bits are 0 after reset and after a seed load.
- R4: The byte that is output is the eight `sdi` values sampled at the eight rising `sck` edges of a transfer, with the first sample in the most significant bit.
- R5: Every output byte is re-sent as the next transmit byte. Starting from a known seed with zero feedback bits, the output stream follows the bit-serial recurrence exactly for at least 64 consecutive bytes.
- R6: `sck` is low while idle. During a transfer its high and low phases each last max(`div_half`, 1) system clock cycles.
- R7: Each completed byte produces exactly one `rnd_valid` pulse, one cycle long, with the byte on `rnd_out`.
- R8: While `rnd_ready` is low, a finished byte is held and no valid pulse appears. When `rnd_ready` returns high, that held byte is delivered and the stream continues unchanged.
- R9: Lowering `enable` during a transfer lets that transfer finish and deliver its byte, but no new transfer starts. Raising `enable` again resumes the same stream.
- R10: A `seed_load` pulse while `enable` is low aborts any transfer in flight, discards it, loads `seed_in` as the next transmit byte and clears both feedback bits. A `seed_load` pulse while `enable` is high is ignored.
- R11: A transfer starts only when the transmit holder is full and the receive holder is empty, so there is no `sck` activity while a received byte waits to be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new transfers to start |
| seed_load | input | 1 | Loads a seed (accepted only while enable is low) |
| seed_in | input | DATA_W | Seed byte |
| div_half | input | DIV_W | System cycles per serial clock half period (0 is treated as 1) |
| rnd_ready | input | 1 | Consumer accepts bytes; low stalls the loop |
| rnd_out | output | DATA_W | Pseudo-random byte |
| rnd_valid | output | 1 | One-cycle pulse per delivered byte |
| sck | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| sdi | output | 1 | Serial data fed back into the engine |

## Verification
The hardest states to reach from the ports are an abort and a stall that land in the middle of a transfer, when some feedback bits have already moved and others have not. The stimulus watches `sck` and acts right after a rising edge. It drops `enable` there, and in a separate run drops `enable` together with a seed load there. In both cases the bench's own bit-serial model must either include the partial byte or throw it away, depending on the case. A running observer of `sdo` and `sdi` checks the XOR feedback on every rising edge. This catches errors in the feedback path even when the byte-level values happen to agree.

// File: rtl/spi_rng_pkg.sv
// Package: shared types for the serial loopback random byte generator.
// Assumes: one serial clock event of each kind at most per system cycle.
package spi_rng_pkg;

    // One-cycle strobes marking serial clock transitions in the system clock domain
    typedef struct packed {
        logic rise;
        logic fall;
    } sck_evt_t;

    localparam logic [7:0] RNG_DEFAULT_SEED = 8'h2C;

endpackage

// File: rtl/rng_sck_gen.sv
// Module: rng_sck_gen
// Makes the serial clock from the system clock while run is high, and flags
// each rising and falling transition as a one-cycle strobe. Each half period
// lasts max(half_i,1) system cycles. The output is forced low when not running.
// Assumes: run drops in the cycle after the last falling strobe or on abort.
module rng_sck_gen
    import spi_rng_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_i,
    output logic             sck_o,
    output sck_evt_t         evt_o
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] half_eff;
    logic             sck_q;
    logic             wrap;

    // Clamp the programmed half period to at least one cycle
    always_comb begin
        half_eff = (half_i == '0) ? DIV_W'(1) : half_i;
        wrap     = run && (cnt_q == half_eff - DIV_W'(1));
    end

    // Count system cycles inside each half period and toggle the clock
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (!run) begin
            cnt_q <= '0;
            sck_q <= 1'b0;
        end else if (wrap) begin
            cnt_q <= '0;
            sck_q <= ~sck_q;
        end else begin
            cnt_q <= cnt_q + DIV_W'(1);
        end
    end

    // Decode transitions and gate the pin with run
    always_comb begin
        evt_o.rise = wrap && !sck_q;
        evt_o.fall = wrap && sck_q;
        sck_o      = sck_q && run;
    end

    // R6
    rise_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.rise |=> sck_q);
    // R6
    fall_then_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_o.fall |=> !sck_q);

endmodule

// File: rtl/rng_feedback.sv
// Module: rng_feedback
// Two-stage delay of the serial data-out line, updated on serial clock rising
// strobes. Its output is the XOR of both stages and serves as serial data-in.
// Assumes: clr_i has priority and models the cleared state after seeding.
module rng_feedback
    import spi_rng_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     clr_i,
    input  sck_evt_t evt_i,
    input  logic     sdo_i,
    output logic     sdi_o
);

    logic stage1_q;
    logic stage2_q;

    // Shift the delay chain on each serial rising edge
    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            stage1_q <= 1'b0;
            stage2_q <= 1'b0;
        end else if (evt_i.rise) begin
            stage1_q <= sdo_i;
            stage2_q <= stage1_q;
        end
    end

    // Fold both stages into the returned bit
    always_comb sdi_o = stage1_q ^ stage2_q;

    // R3
    chain_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_i.rise && !clr_i) |=> (stage2_q == $past(stage1_q)) && (stage1_q == $past(sdo_i)));

endmodule

// File: rtl/rng_shift_core.sv
// Module: rng_shift_core
// Byte-wide full-duplex shift engine. On start it loads the transmit byte and
// drives its MSB on sdo_o. Rising strobes sample sdi_i into the receive
// shifter and falling strobes advance the transmit shifter. After the last
// falling strobe it flags done_o with the assembled byte on rx_o.
// Assumes: start_i only while idle; abort_i wins over everything.
module rng_shift_core
    import spi_rng_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              abort_i,
    input  logic              start_i,
    input  logic [DATA_W-1:0] load_i,
    input  sck_evt_t          evt_i,
    input  logic              sdi_i,
    output logic              busy_o,
    output logic              sdo_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rx_o
);

    localparam int BCW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [BCW-1:0] LAST_BIT = BCW'(DATA_W - 1);

    logic [DATA_W-1:0] tx_sh_q;
    logic [DATA_W-1:0] rx_sh_q;
    logic [BCW-1:0]    bit_q;
    logic              busy_q;
    logic              fall_w;

    always_comb fall_w = evt_i.fall;

    // Sequence one transfer: load, sample on rise, advance on fall
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q  <= 1'b0;
            bit_q   <= '0;
            tx_sh_q <= '0;
            rx_sh_q <= '0;
        end else if (abort_i) begin
            busy_q <= 1'b0;
            bit_q  <= '0;
        end else if (start_i) begin
            busy_q  <= 1'b1;
            bit_q   <= '0;
            tx_sh_q <= load_i;
        end else if (busy_q) begin
            if (evt_i.rise) begin
                rx_sh_q <= {rx_sh_q[DATA_W-2:0], sdi_i};
            end
            if (fall_w) begin
                tx_sh_q <= {tx_sh_q[DATA_W-2:0], 1'b0};
                if (bit_q == LAST_BIT) begin
                    busy_q <= 1'b0;
                    bit_q  <= '0;
                end else begin
                    bit_q <= bit_q + BCW'(1);
                end
            end
        end
    end

    // Drive pins and completion strobe
    always_comb begin
        busy_o = busy_q;
        sdo_o  = busy_q && tx_sh_q[DATA_W-1];
        done_o = busy_q && !abort_i && fall_w && (bit_q == LAST_BIT);
        rx_o   = rx_sh_q;
    end

    // R2
    sdo_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_q && $past(busy_q) && !$past(fall_w) && !$past(abort_i)) |-> $stable(sdo_o));

endmodule

// File: rtl/spi_loop_rng.sv
// Module: spi_loop_rng (top)
// Holds one transmit byte and one received byte around the serial engine.
// When the consumer is ready, a received byte goes out with a one-cycle
// valid pulse and is copied back as the next transmit byte, which keeps the
// loop running. A seed may be loaded while disabled.
// Assumes: rnd_ready is sampled every cycle; div_half may change at any time.
module spi_loop_rng
    import spi_rng_pkg::*;
#(
    parameter int               DATA_W = 8,
    parameter int               DIV_W  = 8,
    parameter logic [DATA_W-1:0] SEED  = DATA_W'(RNG_DEFAULT_SEED)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              seed_load,
    input  logic [DATA_W-1:0] seed_in,
    input  logic [DIV_W-1:0]  div_half,
    input  logic              rnd_ready,
    output logic [DATA_W-1:0] rnd_out,
    output logic              rnd_valid,
    output logic              sck,
    output logic              sdo,
    output logic              sdi
);

    logic [DATA_W-1:0] tx_buf_q;
    logic              tx_full_q;
    logic [DATA_W-1:0] rx_buf_q;
    logic              rx_full_q;
    logic [DATA_W-1:0] rx_byte;
    logic              seed_acc;
    logic              pop;
    logic              start;
    logic              busy;
    logic              done;
    sck_evt_t          evt;

    // Decide seeding, delivery and transfer launch for this cycle
    always_comb begin
        seed_acc = seed_load && !enable;
        pop      = rx_full_q && rnd_ready && !seed_acc;
        start    = enable && tx_full_q && !rx_full_q && !busy && !seed_acc;
    end

    // Maintain the transmit and receive holders and the output register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_buf_q  <= SEED;
            tx_full_q <= 1'b1;
            rx_buf_q  <= '0;
            rx_full_q <= 1'b0;
            rnd_out   <= '0;
            rnd_valid <= 1'b0;
        end else begin
            rnd_valid <= 1'b0;
            if (seed_acc) begin
                tx_buf_q  <= seed_in;
                tx_full_q <= 1'b1;
                rx_full_q <= 1'b0;
            end else begin
                if (start) begin
                    tx_full_q <= 1'b0;
                end
                if (done) begin
                    rx_buf_q  <= rx_byte;
                    rx_full_q <= 1'b1;
                end
                if (pop) begin
                    tx_buf_q  <= rx_buf_q;
                    tx_full_q <= 1'b1;
                    rx_full_q <= 1'b0;
                    rnd_out   <= rx_buf_q;
                    rnd_valid <= 1'b1;
                end
            end
        end
    end

    rng_sck_gen #(.DIV_W(DIV_W)) u_sck (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (busy),
        .half_i (div_half),
        .sck_o  (sck),
        .evt_o  (evt)
    );

    rng_shift_core #(.DATA_W(DATA_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort_i (seed_acc),
        .start_i (start),
        .load_i  (tx_buf_q),
        .evt_i   (evt),
        .sdi_i   (sdi),
        .busy_o  (busy),
        .sdo_o   (sdo),
        .done_o  (done),
        .rx_o    (rx_byte)
    );

    rng_feedback u_fb (
        .clk   (clk),
        .rst_n (rst_n),
        .clr_i (seed_acc),
        .evt_i (evt),
        .sdo_i (sdo),
        .sdi_o (sdi)
    );

    // R7
    valid_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rnd_valid |=> !rnd_valid);
    // R8
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_full_q && !rnd_ready && !seed_acc) |=> (rx_full_q && $stable(rx_buf_q) && !rnd_valid));
    // R11
    no_xfer_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_full_q |-> !busy);

endmodule

// File: tb/spi_loop_rng_tb.sv
`timescale 1ns/1ps
// Directed bench: one task per scenario, each checking its own results
// against a bit-serial model of the loop.
module spi_loop_rng_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       seed_load = 1'b0;
    logic [7:0] seed_in = 8'h00;
    logic [7:0] div_half = 8'd2;
    logic       rnd_ready = 1'b1;
    logic [7:0] rnd_out;
    logic       rnd_valid;
    logic       sck;
    logic       sdo;
    logic       sdi;

    int checks = 0;
    int errors = 0;

    // Bit-serial model state
    logic [7:0] m_tx = 8'h2C;
    logic       m_f1 = 1'b0;
    logic       m_f2 = 1'b0;

    // Pin observer state
    logic       sck_prev = 1'b0;
    logic       sdo_prev = 1'b0;
    logic       sdi_prev = 1'b0;
    logic       bf1 = 1'b0;
    logic       bf2 = 1'b0;
    logic [7:0] sdo_acc = 8'h00;
    logic [7:0] sdi_acc = 8'h00;
    int         rise_cnt = 0;

    always #10 clk = ~clk;

    spi_loop_rng u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .enable    (enable),
        .seed_load (seed_load),
        .seed_in   (seed_in),
        .div_half  (div_half),
        .rnd_ready (rnd_ready),
        .rnd_out   (rnd_out),
        .rnd_valid (rnd_valid),
        .sck       (sck),
        .sdo       (sdo),
        .sdi       (sdi)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, exp);
        end
    endtask

    // Pin observer: values read here are those held during the previous cycle
    always @(posedge clk) begin
        if (rst_n && sck && !sck_prev) begin
            // R3: returned bit is XOR of the two delayed data-out bits
            check(sdi_prev == (bf1 ^ bf2), "R3", "sdi at sck rise", sdi_prev, bf1 ^ bf2);
            bf2 = bf1;
            bf1 = sdo_prev;
            sdo_acc = {sdo_acc[6:0], sdo_prev};
            sdi_acc = {sdi_acc[6:0], sdi_prev};
            rise_cnt++;
        end
        sck_prev = sck;
        sdo_prev = sdo;
        sdi_prev = sdi;
    end

    task automatic model_step(output logic [7:0] nb);
        logic [7:0] r = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            r = {r[6:0], m_f1 ^ m_f2};
            m_f2 = m_f1;
            m_f1 = m_tx[i];
        end
        m_tx = r;
        nb = r;
    endtask

    // Wait for one delivered byte and check it against the model
    task automatic get_byte(input string req);
        int n = 0;
        logic [7:0] sent;
        logic [7:0] expb;
        while (!rnd_valid && n < 4000) begin
            @(negedge clk);
            n++;
        end
        if (!rnd_valid) begin
            check(1'b0, req, "valid timeout", 0, 1);
            return;
        end
        sent = m_tx;
        model_step(expb);
        check(rnd_out == expb, req, "rnd_out", rnd_out, expb);
        // R2: bits seen on sdo were the transmit byte, MSB first
        check(sdo_acc == sent, "R2", "sdo byte", sdo_acc, sent);
        // R4: output byte equals the sdi samples
        check(sdi_acc == rnd_out, "R4", "sdi byte", sdi_acc, rnd_out);
        @(negedge clk);
        // R7: valid lasts one cycle
        check(!rnd_valid, "R7", "valid width", rnd_valid, 0);
    endtask

    task automatic t_reset();
        int r0;
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        r0 = rise_cnt;
        repeat (20) @(negedge clk);
        check(!rnd_valid && !sck && !sdo, "R1", "idle pins after reset",
              {rnd_valid, sck, sdo}, 0);
        check(rise_cnt == r0, "R1", "no sck while disabled", rise_cnt, r0);
        enable = 1'b1;
        get_byte("R1");
        check(rnd_out == 8'h1D, "R1", "first byte from default seed", rnd_out, 8'h1D);
    endtask

    task automatic t_stream();
        div_half = 8'd1;
        for (int k = 0; k < 64; k++) get_byte("R5");
    endtask

    task automatic t_timing(input logic [7:0] h, input int expw);
        int hi = 0;
        int lo = 0;
        int n = 0;
        div_half = h;
        get_byte("R5");
        while (!sck && n < 2000) begin @(negedge clk); n++; end
        while (sck && n < 4000) begin @(negedge clk); hi++; n++; end
        while (!sck && n < 6000) begin @(negedge clk); lo++; n++; end
        check(hi == expw, "R6", "sck high phase", hi, expw);
        check(lo == expw, "R6", "sck low phase", lo, expw);
        get_byte("R5");
    endtask

    task automatic t_stall();
        int r0;
        int vc = 0;
        div_half = 8'd2;
        get_byte("R8");
        rnd_ready = 1'b0;
        repeat (100) @(negedge clk) if (rnd_valid) vc++;
        r0 = rise_cnt;
        repeat (200) @(negedge clk) if (rnd_valid) vc++;
        check(vc == 0, "R8", "no valid while stalled", vc, 0);
        // R11: no transfer while a received byte waits
        check(rise_cnt == r0, "R11", "sck quiet while held", rise_cnt, r0);
        rnd_ready = 1'b1;
        get_byte("R8");
        get_byte("R8");
        get_byte("R8");
    endtask

    task automatic t_enable();
        int r0;
        int vc = 0;
        int n = 0;
        r0 = rise_cnt;
        while (rise_cnt == r0 && n < 2000) begin @(negedge clk); n++; end
        enable = 1'b0;
        get_byte("R9");
        r0 = rise_cnt;
        repeat (100) @(negedge clk) if (rnd_valid) vc++;
        check(vc == 0, "R9", "no valid after disable", vc, 0);
        check(rise_cnt == r0, "R9", "no new transfer after disable", rise_cnt, r0);
        enable = 1'b1;
        get_byte("R9");
        get_byte("R9");
    endtask

    task automatic t_seed();
        int r0;
        int vc = 0;
        int n = 0;
        r0 = rise_cnt;
        while (rise_cnt == r0 && n < 2000) begin @(negedge clk); n++; end
        enable = 1'b0;
        seed_load = 1'b1;
        seed_in = 8'hA5;
        @(negedge clk);
        seed_load = 1'b0;
        m_tx = 8'hA5;
        m_f1 = 1'b0;
        m_f2 = 1'b0;
        bf1 = 1'b0;
        bf2 = 1'b0;
        r0 = rise_cnt;
        repeat (60) @(negedge clk) if (rnd_valid) vc++;
        check(vc == 0, "R10", "aborted byte discarded", vc, 0);
        check(rise_cnt == r0 && !sck, "R10", "idle after seeding", rise_cnt, r0);
        enable = 1'b1;
        for (int k = 0; k < 8; k++) get_byte("R10");
        // Seed while enabled must be ignored
        seed_load = 1'b1;
        seed_in = 8'h00;
        @(negedge clk);
        seed_load = 1'b0;
        for (int k = 0; k < 4; k++) get_byte("R10");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        check(1'b0, "WATCHDOG", "run did not finish", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_stream();
        t_timing(8'd3, 3);
        t_timing(8'd0, 1);
        t_stall();
        t_enable();
        t_seed();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule